// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. Each enabled cycle it takes the current accumulator value, a second operand and a five-bit operation code. It computes the new destination value and the new flag set, and it registers both on the next rising clock edge. The second operand may come from a register, from memory or from an immediate field. The block does not care which one was used, because operand fetch and instruction decode sit outside it.

The five flags are sign, zero, half-carry, parity and carry. They are held in a flag register inside the block and driven straight to the ports. The carry flag also feeds back into the add-with-carry, subtract-with-borrow and rotate-through-carry operations. Each operation touches its own subset of the flags, so the flag register is updated field by field and is not overwritten as a whole. All ports are plain control and data pins. The enable pin qualifies a single operation, and there is no back-pressure.

Top module: `accum_alu`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high, res_q and all five flags read 0.
- R2: When en is low, res_q and all five flags keep their values, whatever op_sel, acc_in and opnd_in carry.
- R3: Add (op 0) gives acc_in + opnd_in, and add-with-carry (op 1) also adds the registered carry. Carry is set on a carry out of bit 7, and half-carry is set on a carry out of bit 3.
- R4: Subtract (op 2) gives acc_in - opnd_in, and subtract-with-borrow (op 3) also subtracts the registered carry. Carry is set when a borrow leaves bit 7, and half-carry is set when a borrow leaves the low nibble. For example, 40h - 20h with carry 1 gives 1Fh with carry 0 and half-carry 1.
- R5: Compare (op 4) sets all five flags exactly as subtract would. res_q takes the unchanged acc_in.
- R6: AND (op 5) clears carry and sets half-carry. XOR (op 6) and OR (op 7) clear both carry and half-carry.
- R7: For ops 0-3 and 5-9, sign equals bit 7 of res_q and zero is set when res_q is 0. Parity is set when res_q has an even number of ones. For op 4, the same rules apply to the internal difference.
- R8: Increment (op 8) and decrement (op 9) write opnd_in + 1 and opnd_in - 1. Half-carry reflects the low-nibble carry or borrow, and carry keeps its old value.
- R9: Rotate-left-circular (op 13) moves bit 7 into bit 0 and into carry. Rotate-right-circular (op 14) moves bit 0 into bit 7 and into carry. Sign, zero, half-carry and parity stay unchanged.
- R10: Rotate-left-through-carry (op 15) shifts left with the old carry entering bit 0, and bit 7 goes to carry. Rotate-right-through-carry (op 16) shifts right with the old carry entering bit 7, and bit 0 goes to carry. Only carry changes among the flags.
- R11: Complement-accumulator (op 10) writes ~acc_in and leaves all flags unchanged. Set-carry (op 11) forces carry to 1, and complement-carry (op 12) inverts carry. Both of these write acc_in to res_q and leave the other flags unchanged.
- R12: Codes 17 to 31 are unassigned. An enabled cycle with one of them changes neither res_q nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 5 | Operation code (see requirements) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand (register, memory or immediate) |
| res_q | output | 8 | Registered destination value |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Half-carry flag |
| flag_p | output | 1 | Even-parity flag |
| flag_cy | output | 1 | Carry / borrow flag |

## Verification
The only hidden state is the carry flag as a feedback input. A wrong carry becomes visible on flag_cy one cycle after the enabled operation that produced it. A later add-with-carry, subtract-with-borrow or rotate-through-carry then spreads it into res_q on the very next enabled cycle. Each test therefore builds a known carry with set-carry or complement-carry and then runs an operation that consumes it. A flag that is wrongly overwritten by an operation which should preserve it shows up at once on the flag ports. For this reason the tests for increment, decrement, rotates and complement-accumulator check all five flags and not only the result.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_CMP = 5'd4,
    OP_AND = 5'd5,
    OP_XOR = 5'd6,
    OP_OR  = 5'd7,
    OP_INC = 5'd8,
    OP_DEC = 5'd9,
    OP_CMA = 5'd10,
    OP_STC = 5'd11,
    OP_CMC = 5'd12,
    OP_RLC = 5'd13,
    OP_RRC = 5'd14,
    OP_RAL = 5'd15,
    OP_RAR = 5'd16
  } alu_op_e;

  localparam int unsigned OP_LAST = 16;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/accum_alu_arith.sv
// One adder shared by add, subtract, compare, increment and decrement.
// Subtraction is done as a + ~b + ~cin; both carries are inverted back to borrows.
module accum_alu_arith #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              hcarry
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;

  always_comb begin
    b_eff  = sub ? ~b : b;
    c_eff  = sub ? ~cin : cin;
    full   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    sum    = full[DATA_W-1:0];
    cout   = full[DATA_W] ^ sub;
    // carry into bit HALF_W recovered from the sum bit
    hcarry = a[HALF_W] ^ b_eff[HALF_W] ^ full[HALF_W] ^ sub;
  end
endmodule

// File: rtl/accum_alu_logic.sv
// Bitwise operations, accumulator complement and the four rotates.
module accum_alu_logic
  import accum_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    res    = a;
    cy_out = cy_in;
    unique case (op)
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_CMA: res = ~a;
      OP_RLC: begin res = {a[MSB-1:0], a[MSB]}; cy_out = a[MSB]; end
      OP_RRC: begin res = {a[0], a[MSB:1]};     cy_out = a[0];   end
      OP_RAL: begin res = {a[MSB-1:0], cy_in};  cy_out = a[MSB]; end
      OP_RAR: begin res = {cy_in, a[MSB:1]};    cy_out = a[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_alu_flags.sv
// Per-operation flag update: each op selects which fields change.
module accum_alu_flags
  import accum_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op,
  input  alu_flags_t        cur,
  input  logic [DATA_W-1:0] arith_val,
  input  logic              arith_cy,
  input  logic              arith_hc,
  input  logic [DATA_W-1:0] logic_val,
  input  logic              logic_cy,
  output alu_flags_t        nxt
);
  function automatic alu_flags_t szp(input logic [DATA_W-1:0] v, input alu_flags_t f);
    alu_flags_t r;
    r   = f;
    r.s = v[DATA_W-1];
    r.z = (v == '0);
    r.p = ~^v;
    return r;
  endfunction

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        nxt    = szp(arith_val, cur);
        nxt.ac = arith_hc;
        nxt.cy = arith_cy;
      end
      OP_INC, OP_DEC: begin
        nxt    = szp(arith_val, cur);
        nxt.ac = arith_hc;
      end
      OP_AND: begin
        nxt    = szp(logic_val, cur);
        nxt.ac = 1'b1;
        nxt.cy = 1'b0;
      end
      OP_XOR, OP_OR: begin
        nxt    = szp(logic_val, cur);
        nxt.ac = 1'b0;
        nxt.cy = 1'b0;
      end
      OP_STC: nxt.cy = 1'b1;
      OP_CMC: nxt.cy = ~cur.cy;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: nxt.cy = logic_cy;
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] res_q,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_p,
  output logic              flag_cy
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  alu_op_e           op_e;
  alu_flags_t        flags_q, flags_d;
  logic [DATA_W-1:0] ar_a, ar_b, ar_sum, lg_res, res_d;
  logic              ar_cin, ar_sub, ar_cout, ar_hc, lg_cy;

  assign op_e = alu_op_e'(op_sel);

  // operand steering for the shared adder
  always_comb begin
    ar_a   = acc_in;
    ar_b   = opnd_in;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    unique case (op_e)
      OP_ADC: ar_cin = flags_q.cy;
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin ar_sub = 1'b1; ar_cin = flags_q.cy; end
      OP_INC: begin ar_a = opnd_in; ar_b = ONE; end
      OP_DEC: begin ar_a = opnd_in; ar_b = ONE; ar_sub = 1'b1; end
      default: ;
    endcase
  end

  accum_alu_arith #(.DATA_W(DATA_W)) arith_i (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_sum), .cout(ar_cout), .hcarry(ar_hc)
  );

  accum_alu_logic #(.DATA_W(DATA_W)) logic_i (
    .op(op_e), .a(acc_in), .b(opnd_in), .cy_in(flags_q.cy),
    .res(lg_res), .cy_out(lg_cy)
  );

  accum_alu_flags #(.DATA_W(DATA_W)) flags_i (
    .op(op_e), .cur(flags_q),
    .arith_val(ar_sum), .arith_cy(ar_cout), .arith_hc(ar_hc),
    .logic_val(lg_res), .logic_cy(lg_cy),
    .nxt(flags_d)
  );

  // destination value select
  always_comb begin
    res_d = res_q;
    unique case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: res_d = ar_sum;
      OP_CMP, OP_STC, OP_CMC: res_d = acc_in;
      OP_AND, OP_XOR, OP_OR, OP_CMA,
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: res_d = lg_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (en) begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign flag_s  = flags_q.s;
  assign flag_z  = flags_q.z;
  assign flag_ac = flags_q.ac;
  assign flag_p  = flags_q.p;
  assign flag_cy = flags_q.cy;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_q) && $stable(flags_q)));

  // R5
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_CMP) |=> (res_q == $past(acc_in)));

  // R6
  logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_sel == OP_AND || op_sel == OP_XOR || op_sel == OP_OR)) |=> !flag_cy);

  // R7
  result_szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_sel <= OP_INC + 1) && op_sel != OP_CMP)
    |=> (flag_z == (res_q == '0) && flag_s == res_q[DATA_W-1] && flag_p == ~^res_q));

  // R8
  incdec_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_sel == OP_INC || op_sel == OP_DEC)) |=> (flag_cy == $past(flag_cy)));

  // R9
  rotate_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel >= OP_RLC && op_sel <= OP_RAR)
    |=> ($stable(flag_s) && $stable(flag_z) && $stable(flag_ac) && $stable(flag_p)));

  // R11
  stc_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_STC) |=> flag_cy);

  // R12
  unused_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel > OP_LAST) |=> ($stable(res_q) && $stable(flags_q)));

endmodule

// File: tb/accum_alu_tb_top.sv
module accum_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic [7:0] res_q;
  logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_alu dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .res_q(res_q),
    .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac),
    .flag_p(flag_p), .flag_cy(flag_cy)
  );

  // flags compared as {s, z, ac, p, cy}
  task automatic check(input string req, input logic [7:0] exp_res, input logic [4:0] exp_f);
    logic [4:0] act_f;
    act_f = {flag_s, flag_z, flag_ac, flag_p, flag_cy};
    checks++;
    if (res_q !== exp_res || act_f !== exp_f) begin
      errors++;
      $display("FAIL %s: res=%02h flags=%05b, expected res=%02h flags=%05b",
               req, res_q, act_f, exp_res, exp_f);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    en = 1'b1; op_sel = op; acc_in = a; opnd_in = b;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", 8'h00, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'h00, 5'b00000);
  endtask

  task automatic t_add();
    run_op(5'd0, 8'h20, 8'h30); check("R3 add 20+30", 8'h50, 5'b00010);
    run_op(5'd0, 8'h99, 8'h99); check("R3 add 99+99 carry", 8'h32, 5'b00101);
    run_op(5'd1, 8'h50, 8'h20); check("R3 adc with cy", 8'h71, 5'b00010);
    run_op(5'd0, 8'hFF, 8'h01); check("R7 add wrap zero", 8'h00, 5'b01111);
  endtask

  task automatic t_sub();
    run_op(5'd2, 8'h50, 8'h30); check("R4 sub 50-30", 8'h20, 5'b00000);
    run_op(5'd2, 8'h10, 8'h20); check("R4 sub borrow", 8'hF0, 5'b10011);
    run_op(5'd3, 8'h40, 8'h20); check("R4 sbb 40-20-1", 8'h1F, 5'b00100);
  endtask

  task automatic t_cmp();
    run_op(5'd4, 8'hB8, 8'hB9); check("R5 cmp less", 8'hB8, 5'b10111);
    run_op(5'd4, 8'hB8, 8'hB8); check("R5 cmp equal", 8'hB8, 5'b01010);
  endtask

  task automatic t_logic();
    run_op(5'd11, 8'h00, 8'h00);
    run_op(5'd5, 8'h55, 8'hB3); check("R6 and", 8'h11, 5'b00110);
    run_op(5'd11, 8'h00, 8'h00);
    run_op(5'd6, 8'hAA, 8'h2D); check("R6 xor", 8'h87, 5'b10010);
    run_op(5'd11, 8'h00, 8'h00);
    run_op(5'd7, 8'hAA, 8'h12); check("R6 or", 8'hBA, 5'b10000);
  endtask

  task automatic t_incdec();
    run_op(5'd11, 8'h00, 8'h00);
    run_op(5'd8, 8'h00, 8'h10); check("R8 inc 10", 8'h11, 5'b00011);
    run_op(5'd8, 8'h00, 8'h0F); check("R8 inc half carry", 8'h10, 5'b00101);
    run_op(5'd9, 8'h00, 8'h20); check("R8 dec 20", 8'h1F, 5'b00101);
    run_op(5'd12, 8'h00, 8'h00);
    run_op(5'd9, 8'h00, 8'h01); check("R8 dec to zero", 8'h00, 5'b01010);
    run_op(5'd8, 8'h00, 8'hFF); check("R8 inc wrap keeps cy", 8'h00, 5'b01110);
  endtask

  task automatic t_rotate();
    // flags enter as 01110 from the previous scenario
    run_op(5'd13, 8'h85, 8'h00); check("R9 rlc", 8'h0B, 5'b01111);
    run_op(5'd14, 8'h85, 8'h00); check("R9 rrc bit0=1", 8'hC2, 5'b01111);
    run_op(5'd14, 8'h02, 8'h00); check("R9 rrc bit0=0", 8'h01, 5'b01110);
    run_op(5'd15, 8'h80, 8'h00); check("R10 ral cy0", 8'h00, 5'b01111);
    run_op(5'd15, 8'h01, 8'h00); check("R10 ral cy1", 8'h03, 5'b01110);
    run_op(5'd16, 8'h01, 8'h00); check("R10 rar cy0", 8'h00, 5'b01111);
    run_op(5'd16, 8'h02, 8'h00); check("R10 rar cy1", 8'h81, 5'b01110);
  endtask

  task automatic t_carry_ops();
    run_op(5'd0, 8'h00, 8'h00);  check("R7 add zero", 8'h00, 5'b01010);
    run_op(5'd10, 8'h55, 8'h00); check("R11 cma", 8'hAA, 5'b01010);
    run_op(5'd11, 8'h12, 8'h00); check("R11 stc", 8'h12, 5'b01011);
    run_op(5'd12, 8'h12, 8'h00); check("R11 cmc 1->0", 8'h12, 5'b01010);
    run_op(5'd12, 8'h12, 8'h00); check("R11 cmc 0->1", 8'h12, 5'b01011);
  endtask

  task automatic t_unused_and_idle();
    run_op(5'd31, 8'h77, 8'h33); check("R12 code 31", 8'h12, 5'b01011);
    run_op(5'd17, 8'h00, 8'hFF); check("R12 code 17", 8'h12, 5'b01011);
    @(negedge clk);
    op_sel = 5'd2; acc_in = 8'hFF; opnd_in = 8'h01;
    repeat (3) @(negedge clk);
    check("R2 idle hold", 8'h12, 5'b01011);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_incdec();
    t_rotate();
    t_carry_ops();
    t_unused_and_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule